// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects 64 level-sensitive interrupt lines and presents the most urgent one to a processor. Software reaches it through a plain 32-bit register bus with a write strobe, a word address and a combinational read path. Each source has its own enable bit. Software sets or clears that bit by writing the source's number to one of two command addresses, so it never needs a read-modify-write on a wide enable word.

Each source carries a 4-bit priority. Eight priorities are packed into each 32-bit priority register. A threshold register hides every source whose priority does not exceed the threshold. An interrupt handler can save this register, raise it to the level it is serving, and restore it afterwards. Every cycle the block chooses the winning source and registers the result. That result drives a single request line and a vector status word. The status word carries the winner's number and its priority, and it reads as a negative number when nothing qualifies.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset all enables, all priority fields and the threshold are zero, the vector status reads 0xFFFFFFFF and the request output is low.
- R2: A write to the enable command address (word 1) whose data is a source number 0..63 sets that source's enable. Every other enable is left unchanged.
- R3: A write to the disable command address (word 2) whose data is a source number 0..63 clears that source's enable. Every other enable is left unchanged.
- R4: An enable or disable command whose 32-bit data value exceeds 63 changes no enable. The bit pattern is not truncated to a smaller source number.
- R5: The priority of source n occupies bits (n mod 8)*4+3 : (n mod 8)*4 of priority group n/8. Group k sits at word address 11-k, so group 0 is at word 11 and group 7 is at word 4. Each group register reads back exactly what was last written to it.
- R6: The threshold register at word 0 is read/write. Its low 4 bits hold the threshold, and bits 31:4 read as zero.
- R7: A source qualifies only when its input is high, its enable is set and its priority is strictly greater than the threshold. A source whose priority equals the threshold does not qualify.
- R8: The vector status at word 3 is read-only. When some source qualifies, bits 31:16 hold the winner's number and bits 15:0 hold its priority. When none qualifies, it reads 0xFFFFFFFF.
- R9: The winner is the qualifying source with the highest priority. Among equal priorities, the higher source number wins.
- R10: The request output is high exactly when the vector status reports a winner. Both reflect the inputs and register state one clock after they are presented.
- R11: Sources are level-sensitive. Once an input drops, that source stops being reported from the next registered result on, and nothing of it is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 64 | Interrupt source levels, bit n is source n |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The directed cases aim at the boundaries that are easiest to get wrong, and each has a recognisable symptom:
- Two sources tie on priority. A design that breaks the tie toward the lower number reports the wrong source.
- A priority equals the threshold. A design that compares with greater-or-equal raises a request that should stay hidden.
- A command value is 69. A design that truncates the value to six bits switches source 5.
- The priority groups use the reversed address layout. A design that places group k at an ascending address sets priorities on the wrong sources.

Random traffic over enables, priorities, thresholds and input levels is checked against a model that scans the sources from the top down. A design with a stale or extra pipeline stage fails on the cycle-exact sampling.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  // Register word addresses
  localparam int ADR_THRESH   = 0;
  localparam int ADR_EN_CMD   = 1;
  localparam int ADR_DIS_CMD  = 2;
  localparam int ADR_VECTOR   = 3;
  localparam int ADR_PRIO_LOW = 4;  // lowest word of the priority group block

  localparam int DEF_NUM_SRC = 64;
  localparam int DEF_PRIO_W  = 4;
  localparam int DEF_DATA_W  = 32;
  localparam int DEF_ADDR_W  = 4;

  // Pack winner into status word: number in upper half, priority in lower half
  function automatic logic [31:0] pack_status(input logic vld, input logic [15:0] num,
                                              input logic [15:0] lvl);
    return vld ? {num, lvl} : 32'hFFFF_FFFF;
  endfunction
endpackage

// File: rtl/pvic_regs.sv
module pvic_regs
  import pvic_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int PRIO_W  = DEF_PRIO_W,
  parameter int DATA_W  = DEF_DATA_W,
  parameter int ADDR_W  = DEF_ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic [DATA_W-1:0]         vec_status,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic [NUM_SRC-1:0]        en_q,
  output logic [NUM_SRC*PRIO_W-1:0] prio_q,
  output logic [PRIO_W-1:0]         thresh_q
);
  localparam int SRC_W    = $clog2(NUM_SRC);
  localparam int PER_REG  = DATA_W / PRIO_W;
  localparam int NUM_PREG = NUM_SRC / PER_REG;
  localparam int PRIO_TOP = ADR_PRIO_LOW + NUM_PREG - 1;

  // Address of priority group g: addresses fall as the group index rises
  function automatic logic [ADDR_W-1:0] group_addr(input int g);
    return ADDR_W'(PRIO_TOP - g);
  endfunction

  // A command value is a valid source number only if no bit above SRC_W is set
  function automatic logic num_in_range(input logic [DATA_W-1:0] v);
    return (v >> SRC_W) == '0;
  endfunction

  // Named events for the assertions
  logic             en_set_fire, en_clr_fire, cmd_ignored;
  logic [SRC_W-1:0] cmd_idx;

  assign cmd_idx     = bus_wdata[SRC_W-1:0];
  assign en_set_fire = bus_wr && (bus_addr == ADDR_W'(ADR_EN_CMD))  && num_in_range(bus_wdata);
  assign en_clr_fire = bus_wr && (bus_addr == ADDR_W'(ADR_DIS_CMD)) && num_in_range(bus_wdata);
  assign cmd_ignored = bus_wr && ((bus_addr == ADDR_W'(ADR_EN_CMD)) ||
                                  (bus_addr == ADDR_W'(ADR_DIS_CMD))) && !num_in_range(bus_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_set_fire) begin
      en_q[cmd_idx] <= 1'b1;
    end else if (en_clr_fire) begin
      en_q[cmd_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thresh_q <= '0;
    end else if (bus_wr && bus_addr == ADDR_W'(ADR_THRESH)) begin
      thresh_q <= bus_wdata[PRIO_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_PREG; g++) begin : g_prio_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[g*DATA_W +: DATA_W] <= '0;
      end else if (bus_wr && bus_addr == group_addr(g)) begin
        prio_q[g*DATA_W +: DATA_W] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADR_THRESH)) bus_rdata = DATA_W'(thresh_q);
    if (bus_addr == ADDR_W'(ADR_VECTOR)) bus_rdata = vec_status;
    for (int g = 0; g < NUM_PREG; g++) begin
      if (bus_addr == group_addr(g)) bus_rdata = prio_q[g*DATA_W +: DATA_W];
    end
  end

  assert_enable_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_fire |=> en_q[$past(cmd_idx)]);
  assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_fire |=> !en_q[$past(cmd_idx)]);
  assert_single_bit_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set_fire || en_clr_fire) |=> ($countones(en_q ^ $past(en_q)) <= 1));
  assert_bad_number_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ignored |=> $stable(en_q));
  assert_thresh_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(ADR_THRESH)) |-> (bus_rdata[DATA_W-1:PRIO_W] == '0));
endmodule

// File: rtl/pvic_pick.sv
module pvic_pick
  import pvic_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int PRIO_W  = DEF_PRIO_W
) (
  input  logic [NUM_SRC-1:0]        src_lvl,
  input  logic [NUM_SRC-1:0]        en_q,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_q,
  input  logic [PRIO_W-1:0]         thresh_q,
  output logic [NUM_SRC-1:0]        qual,
  output logic                      hit,
  output logic [$clog2(NUM_SRC)-1:0] win_id,
  output logic [PRIO_W-1:0]         win_prio
);
  localparam int SRC_W = $clog2(NUM_SRC);

  // Qualification per source: level high, enabled, strictly above threshold
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_qual
    assign qual[n] = src_lvl[n] && en_q[n] && (prio_q[n*PRIO_W +: PRIO_W] > thresh_q);
  end

  // Ascending scan with >= lets the later (higher-numbered) source win a tie
  always_comb begin
    hit      = 1'b0;
    win_id   = '0;
    win_prio = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (qual[n] && (!hit || prio_q[n*PRIO_W +: PRIO_W] >= win_prio)) begin
        hit      = 1'b1;
        win_id   = SRC_W'(n);
        win_prio = prio_q[n*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvic_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int PRIO_W  = DEF_PRIO_W,
  parameter int DATA_W  = DEF_DATA_W,
  parameter int ADDR_W  = DEF_ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_req
);
  localparam int SRC_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]        en_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [PRIO_W-1:0]         thresh_q;
  logic [NUM_SRC-1:0]        qual;
  logic                      hit;
  logic [SRC_W-1:0]          win_id;
  logic [PRIO_W-1:0]         win_prio;
  logic                      vld_r;
  logic [SRC_W-1:0]          id_r;
  logic [PRIO_W-1:0]         lvl_r;
  logic [DATA_W-1:0]         vec_status;
  logic [NUM_SRC-1:0]        live_req;

  pvic_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .vec_status(vec_status), .bus_rdata(bus_rdata), .en_q(en_q), .prio_q(prio_q),
    .thresh_q(thresh_q)
  );

  pvic_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick (
    .src_lvl(src_lvl), .en_q(en_q), .prio_q(prio_q), .thresh_q(thresh_q),
    .qual(qual), .hit(hit), .win_id(win_id), .win_prio(win_prio)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_r <= 1'b0;
      id_r  <= '0;
      lvl_r <= '0;
    end else begin
      vld_r <= hit;
      id_r  <= win_id;
      lvl_r <= win_prio;
    end
  end

  assign vec_status = pack_status(vld_r, 16'(id_r), 16'(lvl_r));
  assign irq_req    = vld_r;
  assign live_req   = src_lvl & en_q;

  // Outrank check: no qualifying source beats the chosen one
  logic outranked;
  always_comb begin
    outranked = 1'b0;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (hit && qual[n] && ((prio_q[n*PRIO_W +: PRIO_W] > win_prio) ||
          (prio_q[n*PRIO_W +: PRIO_W] == win_prio && SRC_W'(n) > win_id)))
        outranked = 1'b1;
    end
  end

  assert_winner_is_best_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !outranked);
  assert_winner_above_thresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vld_r |-> (lvl_r > $past(thresh_q)));
  assert_winner_was_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vld_r |-> ((($past(live_req) >> id_r) & NUM_SRC'(1)) != '0));
  assert_request_follows_any_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (qual != '0) |=> irq_req);
  assert_idle_when_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (qual == '0) |=> !irq_req);
endmodule

// File: tb/test_prio_vec_intc.sv
`timescale 1ns/1ps
module test_prio_vec_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_lvl = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // model state
  logic        m_en [64];
  logic [3:0]  m_pr [64];
  logic [3:0]  m_th;

  prio_vec_intc i_prio_vec_intc (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  always #2.5 clk = ~clk;

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Expected status: scan from top down, replace only on strictly greater priority
  function automatic logic [31:0] exp_status();
    int best = -1;
    int who  = -1;
    for (int n = 63; n >= 0; n--) begin
      if (src_lvl[n] && m_en[n] && (int'(m_pr[n]) > int'(m_th)) && int'(m_pr[n]) > best) begin
        best = int'(m_pr[n]);
        who  = n;
      end
    end
    if (who < 0) return 32'hFFFF_FFFF;
    return {16'(who), 16'(best)};
  endfunction

  function automatic logic [31:0] exp_group(input int k);
    logic [31:0] v = '0;
    for (int j = 0; j < 8; j++) v[j*4 +: 4] = m_pr[k*8 + j];
    return v;
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      4'd0: m_th = d[3:0];
      4'd1: if (d < 64) m_en[d] = 1'b1;
      4'd2: if (d < 64) m_en[d] = 1'b0;
      default: if (a >= 4 && a <= 11)
        for (int j = 0; j < 8; j++) m_pr[(11 - a) * 8 + j] = d[j*4 +: 4];
    endcase
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  // one more edge registers the winner, then sample away from the edge
  task automatic settle_and_check(input string req);
    logic [31:0] st;
    @(posedge clk);
    bus_read(4'd3, st);
    check(req, st, exp_status());
    check({req, " irq"}, 32'(irq_req), 32'(exp_status() != 32'hFFFF_FFFF));
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk);
    src_lvl = v;
  endtask

  task automatic set_prio(input int n, input logic [3:0] p);
    logic [31:0] g = exp_group(n / 8);
    g[(n % 8) * 4 +: 4] = p;
    bus_write(4'(11 - n / 8), g);
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    for (int n = 0; n < 64; n++) begin m_en[n] = 1'b0; m_pr[n] = '0; end
    m_th = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(4'd3, rd); check("R1 status", rd, 32'hFFFF_FFFF);
    check("R1 irq", 32'(irq_req), 32'd0);
    bus_read(4'd0, rd); check("R1 threshold", rd, 32'd0);
    for (int k = 0; k < 8; k++) begin
      bus_read(4'(11 - k), rd); check("R1 prio group", rd, 32'd0);
    end

    // R5 layout: source 9 -> group 1 at word 10, bits 7:4
    bus_write(4'd10, 32'h0000_0050);
    set_src(64'd1 << 9);
    bus_write(4'd1, 32'd9);
    settle_and_check("R5 source 9 layout");
    bus_read(4'd3, rd); check("R5 source 9 priority", rd, {16'd9, 16'd5});
    bus_read(4'd10, rd); check("R5 readback", rd, 32'h0000_0050);

    // R6 threshold readback, upper bits zero
    bus_write(4'd0, 32'hABCD_EF03);
    bus_read(4'd0, rd); check("R6 threshold", rd, 32'd3);
    bus_write(4'd0, 32'd0);

    // R9 tie: 5 and 40 both at priority 7 -> 40 wins
    set_prio(5, 4'd7); set_prio(40, 4'd7); set_prio(9, 4'd0);
    bus_write(4'd1, 32'd5); bus_write(4'd1, 32'd40);
    set_src((64'd1 << 5) | (64'd1 << 40));
    settle_and_check("R9 tie");
    bus_read(4'd3, rd); check("R9 tie winner", rd, {16'd40, 16'd7});

    // R7 threshold equal hides, one below reveals
    bus_write(4'd0, 32'd7);
    settle_and_check("R7 equal threshold");
    bus_read(4'd3, rd); check("R7 hidden", rd, 32'hFFFF_FFFF);
    bus_write(4'd0, 32'd6);
    settle_and_check("R7 below threshold");
    bus_write(4'd0, 32'd0);

    // R3 disable 40 -> 5 reported
    bus_write(4'd2, 32'd40);
    settle_and_check("R3 disable");
    bus_read(4'd3, rd); check("R3 winner after disable", rd, {16'd5, 16'd7});

    // R4 out of range: disable 69 must not touch 5; enable 104 must not touch 40
    bus_write(4'd2, 32'd69);
    bus_write(4'd1, 32'd104);
    settle_and_check("R4 ignored");
    bus_read(4'd3, rd); check("R4 source 5 kept", rd, {16'd5, 16'd7});

    // R11 level drop
    set_src(64'd0);
    settle_and_check("R11 drop");
    check("R11 irq low", 32'(irq_req), 32'd0);

    // R2 enable single source, higher priority wins
    set_prio(63, 4'd15);
    bus_write(4'd1, 32'd63);
    set_src(64'hFFFF_FFFF_FFFF_FFFF);
    settle_and_check("R2 enable 63");
    bus_read(4'd3, rd); check("R8 format", rd, {16'd63, 16'd15});

    // Random mix (R2 R3 R4 R5 R7 R8 R9 R10)
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 6;
      case (op)
        0: bus_write(4'd1, 32'($urandom % 80));
        1: bus_write(4'd2, 32'($urandom % 80));
        2: bus_write(4'(4 + $urandom % 8), $urandom);
        3: bus_write(4'd0, ($urandom % 3 == 0) ? $urandom : 32'($urandom % 6));
        default: set_src({$urandom, $urandom} & {$urandom, $urandom});
      endcase
      settle_and_check("R10 random status");
      if (op == 2) begin
        int k = $urandom % 8;
        bus_read(4'(11 - k), rd); check("R5 random readback", rd, exp_group(k));
      end
    end

    finish_run();
  end
endmodule